// File: doc/BRIEF.md
# USB Control Endpoint Response Unit

This block holds the control state for endpoint zero of a full-speed USB device. It decides, one clock after each decoded token, how that endpoint answers: with a DATA0 or DATA1 packet, with a NAK, with a STALL handshake, or by passing the token on to the receive path. It keeps three CPU-visible registers for the endpoint and a 7-bit function address. Two of these are self-clearing: a one-shot transmit enable, and a default-address override that lets the device answer address 0 until the SET_ADDRESS exchange is over. A status register reports completion, host acknowledgement and the free space of an 8-byte transmit FIFO.

The CPU reaches the registers through a plain strobe port with combinational read data. The packet engine supplies single-cycle token events and "packet sent", "STALL sent" and "ACK received" strobes. The FIFO fill level follows two valid/ready byte streams, one for the CPU filling the FIFO and one for the engine draining it. A byte moves on a stream only in a cycle where valid and ready are both high. Valid may be raised whatever ready is. Ready depends only on the stored fill level and never on valid in the same cycle. Write-ready falls when 8 bytes are held, and read-ready falls when none are held. Token events and the response outputs have no back-pressure.

Top module: `usb_ep0_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 00h, status (address 1) reads 08h, transmit command (address 2) reads 00h and function address (address 3) reads 00h.
- R2: Control bits [3:0] (endpoint number) always read 0 whatever is written. STALL enable is bit 7 and default-address override is bit 6.
- R3: A token matches when its endpoint is 0 and its address equals the function address (override 0) or equals 0 (override 1). Token types are OUT=0, IN=1, SETUP=2 and reserved=3. A matching non-reserved token gives resp_valid high for exactly the cycle after it. Any other token gives no response.
- R4: resp_code values are DATA0=0, DATA1=1, NAK=2, STALL=3 and PASS=4. A matching IN with transmit effective and STALL clear answers DATA0 when TOGGLE (command bit 2) is 0 and DATA1 when it is 1, with tx_start high in the same cycle. An empty FIFO does not change this. Hardware never changes TOGGLE.
- R5: A matching IN answers STALL when STALL enable is set and transmit is effective. It answers NAK when transmit is not effective.
- R6: A matching OUT answers STALL when STALL enable is set and rx_en is 1, and PASS otherwise. SETUP always answers PASS.
- R7: Transmit is effective only when TX_EN (command bit 0) is 1 and rx_en is 0. While rx_en is 1, an IN answers NAK and TX_EN keeps its value.
- R8: pkt_sent sets TX_DONE (status bit 5) and clears both TX_EN and the default-address override.
- R9: stall_sent sets TX_DONE and pulses rx_last in the next cycle. It clears TX_EN only when the last STALL answered an IN.
- R10: host_ack sets ACK_STAT (status bit 6).
- R11: A CPU read of the status register clears TX_DONE and ACK_STAT. A set arriving in the same cycle wins over the clear.
- R12: Status bits [3:0] report the free FIFO bytes (8 minus the held bytes). Accepted writes add one byte and accepted reads remove one. A write offered when full and a read offered when empty are ignored.
- R13: A CPU write to the command or control register wins over a hardware clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (triggers read-clear) |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr |
| tok_valid | input | 1 | Token event |
| tok_type | input | 2 | Token type |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 4 | Token endpoint number |
| rx_en | input | 1 | Receive direction enabled |
| pkt_sent | input | 1 | Data packet finished transmitting |
| stall_sent | input | 1 | STALL handshake finished transmitting |
| host_ack | input | 1 | ACK received from host |
| fifo_wr_valid | input | 1 | Byte offered into transmit FIFO |
| fifo_wr_ready | output | 1 | FIFO has room |
| fifo_rd_valid | input | 1 | Engine takes a byte from the FIFO |
| fifo_rd_ready | output | 1 | FIFO holds a byte |
| resp_valid | output | 1 | Response decision valid |
| resp_code | output | 3 | Response choice |
| tx_start | output | 1 | Start data packet transmission |
| rx_last | output | 1 | Receive-last indication after a STALL |

## Verification
The bench targets collisions and priority corners. A status read in the same cycle as an ACK must keep the ACK, or the acknowledgement is lost. A CPU write in the same cycle as a packet completion must keep the written value, or a freshly armed transmission is dropped. A STALL answering an OUT must leave TX_EN armed, where a careless design would disarm it. Other targets are tokens under the default-address override, SETUP with STALL set (which must not stall), and rx_en blocking a set TX_EN. At the FIFO edges the bench offers writes when full, reads when empty, and both at once, so a design that accepts past full or miscounts the combined move shows a wrong free count.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;
  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_e;

  typedef enum logic [2:0] {
    RSP_DATA0 = 3'd0,
    RSP_DATA1 = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_PASS  = 3'd4
  } rsp_e;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_STAT  = 2'd1;
  localparam logic [1:0] RA_CMD   = 2'd2;
  localparam logic [1:0] RA_FADDR = 2'd3;

  localparam int CTL_STALL_B = 7;
  localparam int CTL_DEF_B   = 6;
  localparam int ST_ACK_B    = 6;
  localparam int ST_DONE_B   = 5;
  localparam int CMD_TOG_B   = 2;
  localparam int CMD_EN_B    = 0;
  localparam int FREE_W      = 4;
endpackage

// File: rtl/ep0_fill_tracker.sv
module ep0_fill_tracker #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          rd_valid,
  output logic          rd_ready,
  output logic [CW-1:0] free_cnt
);
  logic [CW-1:0] held;
  logic wr_acc, rd_acc;

  assign wr_ready = (held != CW'(DEPTH));
  assign rd_ready = (held != '0);
  assign wr_acc   = wr_valid && wr_ready;
  assign rd_acc   = rd_valid && rd_ready;
  assign free_cnt = CW'(DEPTH) - held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
    end else if (wr_acc && !rd_acc) begin
      held <= held + CW'(1);
    end else if (rd_acc && !wr_acc) begin
      held <= held - CW'(1);
    end
  end

  AST_FREE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(rd_valid && rd_ready)) |=> free_cnt == $past(free_cnt) - CW'(1)) else $error("free count step"); // R12
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !rd_valid) |=> !wr_ready) else $error("accepted past full"); // R12
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(DEPTH)) else $error("free over depth"); // R12
endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
  import usb_ep0_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic [FREE_W-1:0] free_cnt,
  input  logic              pkt_sent,
  input  logic              stall_sent,
  input  logic              stall_was_in,
  input  logic              host_ack,
  output logic              stall_en,
  output logic              def_en,
  output logic              toggle,
  output logic              tx_en,
  output logic [ADDR_W-1:0] faddr
);
  logic tx_done, ack_stat;
  logic wr_ctrl, wr_cmd, wr_fa, rd_stat;

  assign wr_ctrl = cpu_wr && (cpu_addr == RA_CTRL);
  assign wr_cmd  = cpu_wr && (cpu_addr == RA_CMD);
  assign wr_fa   = cpu_wr && (cpu_addr == RA_FADDR);
  assign rd_stat = cpu_rd && (cpu_addr == RA_STAT);

  // control register: the endpoint number field is fixed at zero
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_en <= 1'b0;
      def_en   <= 1'b0;
    end else if (wr_ctrl) begin
      stall_en <= cpu_wdata[CTL_STALL_B];
      def_en   <= cpu_wdata[CTL_DEF_B];
    end else if (pkt_sent) begin
      def_en   <= 1'b0;
    end
  end

  // transmit command: one-shot enable, software-owned toggle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      toggle <= 1'b0;
    end else if (wr_cmd) begin
      tx_en  <= cpu_wdata[CMD_EN_B];
      toggle <= cpu_wdata[CMD_TOG_B];
    end else if (pkt_sent || (stall_sent && stall_was_in)) begin
      tx_en  <= 1'b0;
    end
  end

  // status: a set event outranks the read-clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_done  <= 1'b0;
      ack_stat <= 1'b0;
    end else begin
      if (pkt_sent || stall_sent) tx_done <= 1'b1;
      else if (rd_stat)           tx_done <= 1'b0;
      if (host_ack)               ack_stat <= 1'b1;
      else if (rd_stat)           ack_stat <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     faddr <= '0;
    else if (wr_fa) faddr <= cpu_wdata[ADDR_W-1:0];
  end

  always_comb begin
    cpu_rdata = 8'h00;
    case (cpu_addr)
      RA_CTRL: begin
        cpu_rdata[CTL_STALL_B] = stall_en;
        cpu_rdata[CTL_DEF_B]   = def_en;
      end
      RA_STAT: begin
        cpu_rdata[ST_ACK_B]     = ack_stat;
        cpu_rdata[ST_DONE_B]    = tx_done;
        cpu_rdata[FREE_W-1:0]   = free_cnt;
      end
      RA_CMD: begin
        cpu_rdata[CMD_TOG_B] = toggle;
        cpu_rdata[CMD_EN_B]  = tx_en;
      end
      default: cpu_rdata[ADDR_W-1:0] = faddr;
    endcase
  end

  AST_DONE_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent || stall_sent) |=> tx_done) else $error("done not set"); // R8
  AST_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && !wr_cmd) |=> !tx_en) else $error("enable kept"); // R8
  AST_TOGGLE_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(toggle)) else $error("toggle moved"); // R4
  AST_ACK_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && rd_stat) |=> ack_stat) else $error("ack lost"); // R11
endmodule

// File: rtl/ep0_responder.sv
module ep0_responder
  import usb_ep0_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_type,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              stall_en,
  input  logic              def_en,
  input  logic              tx_en,
  input  logic              toggle,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] faddr,
  input  logic              stall_sent,
  output logic              resp_valid,
  output logic [2:0]        resp_code,
  output logic              tx_start,
  output logic              rx_last,
  output logic              stall_was_in
);
  tok_e ty;
  rsp_e nxt;
  logic hit, tx_live, nxt_valid, nxt_start;

  assign ty      = tok_e'(tok_type);
  assign tx_live = tx_en && !rx_en;

  always_comb begin
    hit       = (tok_ep == '0) && (def_en ? (tok_addr == '0) : (tok_addr == faddr));
    nxt_valid = tok_valid && hit && (ty != TOK_RSVD);
    nxt       = RSP_PASS;
    nxt_start = 1'b0;
    case (ty)
      TOK_IN: begin
        if (!tx_live)      nxt = RSP_NAK;
        else if (stall_en) nxt = RSP_STALL;
        else begin
          nxt       = toggle ? RSP_DATA1 : RSP_DATA0;
          nxt_start = 1'b1;
        end
      end
      TOK_OUT: nxt = (stall_en && rx_en) ? RSP_STALL : RSP_PASS;
      default: nxt = RSP_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_code    <= RSP_PASS;
      tx_start     <= 1'b0;
      rx_last      <= 1'b0;
      stall_was_in <= 1'b0;
    end else begin
      resp_valid <= nxt_valid;
      resp_code  <= nxt;
      tx_start   <= nxt_valid && nxt_start;
      rx_last    <= stall_sent;
      if (nxt_valid && (nxt == RSP_STALL)) stall_was_in <= (ty == TOK_IN);
    end
  end

  AST_SETUP_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ty == TOK_SETUP) |=> resp_code != RSP_STALL) else $error("setup stalled"); // R6
  AST_START_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (resp_valid && resp_code <= RSP_DATA1)) else $error("start without data"); // R4
  AST_RX_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && rx_en) |=> !tx_start) else $error("tx while rx"); // R7
  AST_FOREIGN_EP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ep != '0) |=> !resp_valid) else $error("foreign ep answered"); // R3
endmodule

// File: rtl/usb_ep0_ctrl.sv
module usb_ep0_ctrl
  import usb_ep0_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int EP_W       = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              tok_valid,
  input  logic [1:0]        tok_type,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              rx_en,
  input  logic              pkt_sent,
  input  logic              stall_sent,
  input  logic              host_ack,
  input  logic              fifo_wr_valid,
  output logic              fifo_wr_ready,
  input  logic              fifo_rd_valid,
  output logic              fifo_rd_ready,
  output logic              resp_valid,
  output logic [2:0]        resp_code,
  output logic              tx_start,
  output logic              rx_last
);
  logic [CW-1:0]     free_raw;
  logic [FREE_W-1:0] free_fld;
  logic stall_en, def_en, toggle, tx_en, stall_was_in;
  logic [ADDR_W-1:0] faddr;

  assign free_fld = FREE_W'(free_raw);

  ep0_fill_tracker #(.DEPTH(FIFO_DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(fifo_wr_valid), .wr_ready(fifo_wr_ready),
    .rd_valid(fifo_rd_valid), .rd_ready(fifo_rd_ready),
    .free_cnt(free_raw)
  );

  ep0_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .free_cnt(free_fld), .pkt_sent(pkt_sent), .stall_sent(stall_sent),
    .stall_was_in(stall_was_in), .host_ack(host_ack),
    .stall_en(stall_en), .def_en(def_en), .toggle(toggle),
    .tx_en(tx_en), .faddr(faddr)
  );

  ep0_responder #(.ADDR_W(ADDR_W), .EP_W(EP_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_type(tok_type), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .stall_en(stall_en), .def_en(def_en), .tx_en(tx_en), .toggle(toggle),
    .rx_en(rx_en), .faddr(faddr), .stall_sent(stall_sent),
    .resp_valid(resp_valid), .resp_code(resp_code), .tx_start(tx_start),
    .rx_last(rx_last), .stall_was_in(stall_was_in)
  );

  AST_DEF_CLEARS_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && !(cpu_wr && cpu_addr == RA_CTRL)) |=> !def_en) else $error("override kept"); // R8
endmodule

// File: tb/usb_ep0_ctrl_tb.sv
module usb_ep0_ctrl_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [1:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic tok_valid = 0;
  logic [1:0] tok_type = 0;
  logic [6:0] tok_addr = 0;
  logic [3:0] tok_ep = 0;
  logic rx_en = 0, pkt_sent = 0, stall_sent = 0, host_ack = 0;
  logic fifo_wr_valid = 0, fifo_rd_valid = 0;
  logic fifo_wr_ready, fifo_rd_ready, resp_valid, tx_start, rx_last;
  logic [2:0] resp_code;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(PERIOD/2) clk = ~clk;

  usb_ep0_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid),
    .tok_type(tok_type), .tok_addr(tok_addr), .tok_ep(tok_ep), .rx_en(rx_en),
    .pkt_sent(pkt_sent), .stall_sent(stall_sent), .host_ack(host_ack),
    .fifo_wr_valid(fifo_wr_valid), .fifo_wr_ready(fifo_wr_ready),
    .fifo_rd_valid(fifo_rd_valid), .fifo_rd_ready(fifo_rd_ready),
    .resp_valid(resp_valid), .resp_code(resp_code), .tx_start(tx_start), .rx_last(rx_last)
  );

  // behavioural reference, updated from the same inputs every edge
  int m_stall, m_def, m_tog, m_txen, m_done, m_ack, m_fa, m_used, m_lastin;
  int m_rv, m_rc, m_ts, m_rl;

  function automatic int model_rd(input int a);
    case (a)
      0: return m_stall * 128 + m_def * 64;
      1: return m_ack * 64 + m_done * 32 + (8 - m_used);
      2: return m_tog * 4 + m_txen;
      default: return m_fa;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stall = 0; m_def = 0; m_tog = 0; m_txen = 0; m_done = 0; m_ack = 0;
      m_fa = 0; m_used = 0; m_lastin = 0; m_rv = 0; m_rc = 4; m_ts = 0; m_rl = 0;
    end else begin
      int live, hit, wa, ra, old_lastin;
      old_lastin = m_lastin;
      live = (m_txen != 0) && !rx_en;
      hit = (tok_ep == 0) && (m_def != 0 ? tok_addr == 0 : int'(tok_addr) == m_fa);
      m_rv = 0; m_ts = 0; m_rc = 4;
      if (tok_valid && hit && tok_type != 3) begin
        m_rv = 1;
        if (tok_type == 1) begin
          if (!live) m_rc = 2;
          else if (m_stall != 0) begin m_rc = 3; m_lastin = 1; end
          else begin m_rc = m_tog; m_ts = 1; end
        end else if (tok_type == 0 && m_stall != 0 && rx_en) begin
          m_rc = 3; m_lastin = 0;
        end
      end
      m_rl = stall_sent;
      if (pkt_sent || stall_sent) m_done = 1;
      else if (cpu_rd && cpu_addr == 1) m_done = 0;
      if (host_ack) m_ack = 1;
      else if (cpu_rd && cpu_addr == 1) m_ack = 0;
      if (cpu_wr && cpu_addr == 2) begin
        m_txen = cpu_wdata[0]; m_tog = cpu_wdata[2];
      end else if (pkt_sent || (stall_sent && old_lastin != 0)) m_txen = 0;
      if (cpu_wr && cpu_addr == 0) begin
        m_stall = cpu_wdata[7]; m_def = cpu_wdata[6];
      end else if (pkt_sent) m_def = 0;
      if (cpu_wr && cpu_addr == 3) m_fa = cpu_wdata[6:0];
      wa = (fifo_wr_valid && m_used < 8) ? 1 : 0;
      ra = (fifo_rd_valid && m_used > 0) ? 1 : 0;
      m_used = m_used + wa - ra;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(resp_valid == m_rv, "R3 resp_valid", resp_valid, m_rv);
      if (m_rv != 0) chk(int'(resp_code) == m_rc, "R5 resp_code", resp_code, m_rc);
      chk(tx_start == m_ts, "R4 tx_start", tx_start, m_ts);
      chk(rx_last == m_rl, "R9 rx_last", rx_last, m_rl);
      chk(fifo_wr_ready == (m_used < 8), "R12 wr_ready", fifo_wr_ready, m_used < 8);
      chk(fifo_rd_ready == (m_used > 0), "R12 rd_ready", fifo_rd_ready, m_used > 0);
      chk(int'(cpu_rdata) == model_rd(cpu_addr),
          cpu_addr == 0 ? "R2 ctrl" : cpu_addr == 1 ? "R11 stat" : cpu_addr == 2 ? "R8 cmd" : "R1 faddr",
          cpu_rdata, model_rd(cpu_addr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
    cpu_wr = 0; cpu_rd = 0; tok_valid = 0; pkt_sent = 0; stall_sent = 0;
    host_ack = 0; fifo_wr_valid = 0; fifo_rd_valid = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d; step();
  endtask

  task automatic rd_stat();
    cpu_rd = 1; cpu_addr = 2'd1; step();
  endtask

  task automatic tok(input logic [1:0] t, input logic [6:0] a, input logic [3:0] e);
    tok_valid = 1; tok_type = t; tok_addr = a; tok_ep = e; step();
  endtask

  task automatic expect_resp(input bit v, input int code, input string tag);
    #1;
    chk(resp_valid == v, tag, resp_valid, v);
    if (v) chk(int'(resp_code) == code, tag, resp_code, code);
  endtask

  task automatic peek(input logic [1:0] a, input int exp, input string tag);
    cpu_addr = a; #1;
    chk(int'(cpu_rdata) == exp, tag, cpu_rdata, exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    peek(0, 8'h00, "R1 ctrl reset"); peek(1, 8'h08, "R1 stat reset");
    peek(2, 8'h00, "R1 cmd reset");  peek(3, 8'h00, "R1 faddr reset");
    chk(fifo_wr_ready && !fifo_rd_ready, "R12 ready at reset", {fifo_wr_ready, fifo_rd_ready}, 2);

    wr(0, 8'h0F); peek(0, 8'h00, "R2 ep bits");
    wr(0, 8'hCF); peek(0, 8'hC0, "R2 ep bits with flags");
    wr(0, 8'h00);

    wr(3, 8'h25);
    tok(1, 7'h25, 0); expect_resp(1, 2, "R5 IN disabled NAK");
    tok(1, 7'h24, 0); expect_resp(0, 0, "R3 wrong address");
    tok(1, 7'h25, 1); expect_resp(0, 0, "R3 wrong endpoint");
    tok(3, 7'h25, 0); expect_resp(0, 0, "R3 reserved type");

    wr(2, 8'h01);
    tok(1, 7'h25, 0); expect_resp(1, 0, "R4 DATA0 zero length");
    chk(tx_start, "R4 tx_start", tx_start, 1);
    pkt_sent = 1; step();
    peek(1, 8'h28, "R8 done set"); peek(2, 8'h00, "R8 enable cleared");
    rd_stat(); peek(1, 8'h08, "R11 read clears");

    wr(2, 8'h05);
    tok(1, 7'h25, 0); expect_resp(1, 1, "R4 DATA1");
    host_ack = 1; step();
    pkt_sent = 1; step();
    peek(1, 8'h68, "R10 ack set"); peek(2, 8'h04, "R4 toggle kept");
    rd_stat();

    rx_en = 1; wr(2, 8'h05);
    tok(1, 7'h25, 0); expect_resp(1, 2, "R7 rx_en blocks");
    chk(!tx_start, "R7 no start", tx_start, 0);
    peek(2, 8'h05, "R7 enable kept");
    rx_en = 0; wr(2, 8'h00);

    wr(0, 8'h80);
    rx_en = 1; tok(0, 7'h25, 0); expect_resp(1, 3, "R6 OUT stall");
    rx_en = 0; tok(0, 7'h25, 0); expect_resp(1, 4, "R6 OUT pass");
    rx_en = 1; tok(2, 7'h25, 0); expect_resp(1, 4, "R6 SETUP never stalls");
    rx_en = 0; tok(1, 7'h25, 0); expect_resp(1, 2, "R5 stall but disabled NAK");
    wr(2, 8'h01);
    tok(1, 7'h25, 0); expect_resp(1, 3, "R5 IN stall");
    chk(!tx_start, "R5 no start on stall", tx_start, 0);
    stall_sent = 1; step(); #1;
    chk(rx_last, "R9 rx_last pulse", rx_last, 1);
    peek(2, 8'h00, "R9 enable cleared"); peek(1, 8'h28, "R9 done set");
    rd_stat();
    wr(2, 8'h01); rx_en = 1;
    tok(0, 7'h25, 0); expect_resp(1, 3, "R9 OUT stall");
    stall_sent = 1; step();
    peek(2, 8'h01, "R9 OUT stall keeps enable");
    rx_en = 0; wr(2, 8'h00); wr(0, 8'h00); rd_stat();

    wr(0, 8'h40);
    tok(1, 7'h00, 0); expect_resp(1, 2, "R3 default address hit");
    tok(1, 7'h25, 0); expect_resp(0, 0, "R3 assigned address ignored");
    wr(2, 8'h01);
    tok(1, 7'h00, 0); expect_resp(1, 0, "R3 default DATA0");
    pkt_sent = 1; step();
    peek(0, 8'h00, "R8 override cleared");
    tok(1, 7'h25, 0); expect_resp(1, 2, "R3 assigned address back");
    rd_stat();

    host_ack = 1; cpu_rd = 1; cpu_addr = 1; step();
    peek(1, 8'h48, "R11 set wins over clear");
    rd_stat();

    wr(0, 8'h40);
    cpu_wr = 1; cpu_addr = 2; cpu_wdata = 8'h01; pkt_sent = 1; step();
    peek(2, 8'h01, "R13 cmd write wins");
    cpu_wr = 1; cpu_addr = 0; cpu_wdata = 8'h40; pkt_sent = 1; step();
    peek(0, 8'h40, "R13 ctrl write wins");
    wr(0, 8'h00); wr(2, 8'h00); rd_stat();

    for (int i = 0; i < 8; i++) begin fifo_wr_valid = 1; step(); end
    peek(1, 8'h00, "R12 full");
    chk(!fifo_wr_ready, "R12 wr_ready low when full", fifo_wr_ready, 0);
    fifo_wr_valid = 1; step(); peek(1, 8'h00, "R12 write when full ignored");
    fifo_wr_valid = 1; fifo_rd_valid = 1; step(); peek(1, 8'h01, "R12 both at full");
    fifo_wr_valid = 1; fifo_rd_valid = 1; step(); peek(1, 8'h01, "R12 both mid");
    for (int i = 0; i < 7; i++) begin fifo_rd_valid = 1; step(); end
    peek(1, 8'h08, "R12 drained");
    fifo_rd_valid = 1; step(); peek(1, 8'h08, "R12 read when empty ignored");
    chk(!fifo_rd_ready, "R12 rd_ready low when empty", fifo_rd_ready, 0);
    fifo_wr_valid = 1; fifo_rd_valid = 1; step(); peek(1, 8'h07, "R12 both at empty");
    fifo_rd_valid = 1; step(); peek(1, 8'h08, "R12 back to empty");
    repeat (3) step();

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule